// File: doc/BRIEF.md
# Operand Dependence Resolver for a Five-Stage Pipeline

This block watches an in-order pipeline with five stages: fetch, decode with operand read, ALU, data memory and register write. Each cycle it compares the source registers of the instruction now in decode with the destination registers of the valid instructions in the ALU, memory and write-back stages. For every operand the decode instruction reads, it names which stage supplies the freshest value. It raises a freeze when no forwarding path can deliver that value before the consumer needs it. Every register write happens in the last stage and in issue order, so only read-after-write dependences are possible, and only those are checked.

How soon a value can be used depends on both ends of the dependence. A producer's value appears after the ALU stage, or after the memory stage if the producer is a load. A consumer needs its value by a fixed stage: stage 2 for branch target and condition, stage 3 for ALU operands and address modifiers, and stage 4 for the value a store writes. The outputs are combinational from the present stage contents. Fetch and decode hold while the freeze is high, and a nop enters the ALU stage in those same cycles. The freeze therefore lasts exactly as many cycles as the dependence needs. There is no data stream through the block, so all pins are plain level signals with no valid/ready handshake. The clock and reset serve only to sample the embedded checks.

Top module: `hzfwd_unit`

## Requirements
- R1: When decode holds no valid instruction, or no valid producer matches an operand it reads, every select code is 0 (register file) and pause and bubble are low.
- R2: Class codes decide which operands are read. Alu (0) reads rb, and reads rc only when the rc-is-register flag is 1. Load (1) and ladr (2) read rb. Brl (3) and branch (5) read rb and rc. Store (4) reads rb, and reads ra as its data. Codes 6 and 7 read nothing. An operand that is not read always gets code 0.
- R3: Only classes alu, load, ladr and brl write a register, and they write the one named in ra. Store, branch and codes 6/7 never act as a source. Register 0 is compared like any other register.
- R4: A select code of 1, 2 or 3 names the ALU, memory or write-back stage as the source. When several valid producers match, the youngest one wins: the ALU stage beats memory, and memory beats write-back.
- R5: A producer at distance d (1 to 3 stages ahead of decode) with availability stage e forces a pause when need + d <= e. Here e is 3 for alu/ladr/brl and 4 for load. The need stage is 2 for branch/brl operands, 3 for the alu operands and for the load, ladr and store address, and 4 for store data. Only the youngest matching producer is judged.
- R6: A load followed at once by an instruction that reads the loaded register by stage 3 causes a pause. A load followed at once by a store whose data register is the loaded one causes no pause and selects code 1.
- R7: A load feeding a branch target pauses both when the branch follows directly and when one other instruction separates them.
- R8: An alu or ladr result used by the branch directly after it causes a pause; with one instruction between them it does not.
- R9: Bubble equals pause in every cycle, and pause is never high while decode is empty.
- R10: In a running pipeline, a consumer that directly follows its producer is held in decode for exactly this many cycles: load-to-branch 2, alu-to-branch 1, load-to-alu 1, load-to-store-data 0. A load-to-branch pair with one instruction between is held 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the embedded checks |
| rst_n | input | 1 | Active-low reset that disables the checks |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_class | input | 3 | Class code of the decode instruction |
| dec_ra | input | REG_W | ra field of the decode instruction (store data source) |
| dec_rb | input | REG_W | rb field of the decode instruction |
| dec_rc | input | REG_W | rc field of the decode instruction |
| dec_rc_reg | input | 1 | For alu class: second operand is a register, not a constant |
| ex_valid | input | 1 | ALU stage holds an instruction |
| ex_class | input | 3 | Class code in the ALU stage |
| ex_ra | input | REG_W | Destination field in the ALU stage |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_class | input | 3 | Class code in the memory stage |
| mem_ra | input | REG_W | Destination field in the memory stage |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_class | input | 3 | Class code in the write-back stage |
| wb_ra | input | REG_W | Destination field in the write-back stage |
| fwd_a | output | 2 | Select code for the store data operand (ra) |
| fwd_b | output | 2 | Select code for the rb operand |
| fwd_c | output | 2 | Select code for the rc operand |
| pause | output | 1 | Freeze fetch and decode this cycle |
| bubble | output | 1 | Inject a nop into the ALU stage this cycle |

## Verification
The bench builds the block with its default 5-bit register fields. Random register numbers are drawn from only four values, so matches at one, two and three stages of distance, and several matches at once, come up often. Random class codes, including the two unused ones, cover every pairing of producer and consumer timing. A small modelled pipeline then shows how many cycles each classic dependence pair is held, and which stage it finally forwards from.

// File: rtl/hzfwd_pkg.sv
package hzfwd_pkg;

  // number of stages ahead of decode that may hold a producer
  parameter int unsigned PROD_STAGES = 3;
  // number of operands a decode instruction may read
  parameter int unsigned NUM_OPS = 3;

  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_LOAD   = 3'd1,
    CLS_LADR   = 3'd2,
    CLS_BRL    = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_BRANCH = 3'd5,
    CLS_RSV6   = 3'd6,
    CLS_RSV7   = 3'd7
  } ins_cls_e;

  typedef logic [1:0] fwd_sel_t;

  localparam fwd_sel_t FWD_RF  = 2'd0;
  localparam fwd_sel_t FWD_EX  = 2'd1;
  localparam fwd_sel_t FWD_MEM = 2'd2;
  localparam fwd_sel_t FWD_WB  = 2'd3;

  // stage by which each operand kind must hold its value
  localparam logic [2:0] NEED_BRANCH = 3'd2;
  localparam logic [2:0] NEED_ALU    = 3'd3;
  localparam logic [2:0] NEED_STDATA = 3'd4;

  function automatic logic cls_writes(input logic [2:0] c);
    case (c)
      CLS_ALU, CLS_LOAD, CLS_LADR, CLS_BRL: cls_writes = 1'b1;
      default:                              cls_writes = 1'b0;
    endcase
  endfunction

  // stage at whose output the produced value first exists
  function automatic logic [2:0] cls_ready_stage(input logic [2:0] c);
    if (c == CLS_LOAD) cls_ready_stage = 3'd4;
    else               cls_ready_stage = 3'd3;
  endfunction

endpackage

// File: rtl/hzfwd_use_decode.sv
module hzfwd_use_decode
  import hzfwd_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] cls,
  input  logic       rc_reg,
  output logic       use_a,
  output logic       use_b,
  output logic       use_c,
  output logic [2:0] need_a,
  output logic [2:0] need_b,
  output logic [2:0] need_c
);

  logic is_branchy;

  always_comb begin
    is_branchy = (cls == CLS_BRANCH) || (cls == CLS_BRL);
    use_a = 1'b0;
    use_b = 1'b0;
    use_c = 1'b0;
    if (valid) begin
      case (cls)
        CLS_ALU:             begin use_b = 1'b1; use_c = rc_reg; end
        CLS_LOAD, CLS_LADR:  use_b = 1'b1;
        CLS_STORE:           begin use_b = 1'b1; use_a = 1'b1; end
        CLS_BRL, CLS_BRANCH: begin use_b = 1'b1; use_c = 1'b1; end
        default:             ;
      endcase
    end
    need_a = NEED_STDATA;
    need_b = is_branchy ? NEED_BRANCH : NEED_ALU;
    need_c = is_branchy ? NEED_BRANCH : NEED_ALU;
  end

endmodule

// File: rtl/hzfwd_operand.sv
module hzfwd_operand
  import hzfwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                used,
  input  logic [REG_W-1:0]                    src,
  input  logic [2:0]                          need,
  input  logic [PROD_STAGES-1:0]              prod_valid,
  input  logic [PROD_STAGES-1:0][2:0]         prod_cls,
  input  logic [PROD_STAGES-1:0][REG_W-1:0]   prod_ra,
  output fwd_sel_t                            fwd,
  output logic                                stall
);

  logic [PROD_STAGES-1:0] hit;
  logic [PROD_STAGES-1:0] late;

  // index 0 is the stage right after decode (distance 1)
  for (genvar i = 0; i < PROD_STAGES; i++) begin : g_stage
    assign hit[i]  = used && prod_valid[i] && cls_writes(prod_cls[i]) &&
                     (prod_ra[i] == src);
    assign late[i] = ({1'b0, need} + 4'(i + 1)) <=
                     {1'b0, cls_ready_stage(prod_cls[i])};
  end

  // oldest first so the youngest match is written last and wins
  always_comb begin
    fwd   = FWD_RF;
    stall = 1'b0;
    for (int i = PROD_STAGES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        fwd   = fwd_sel_t'(i + 1);
        stall = late[i];
      end
    end
  end

  p_unused_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !used |-> (fwd == FWD_RF) && !stall);

  p_ex_select_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd == FWD_EX) |-> prod_valid[0] && (prod_ra[0] == src));

  p_store_not_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_cls[0] == CLS_STORE) |-> (fwd != FWD_EX));

  p_wb_never_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd == FWD_WB) |-> !stall);

endmodule

// File: rtl/hzfwd_unit.sv
module hzfwd_unit
  import hzfwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [2:0]       dec_class,
  input  logic [REG_W-1:0] dec_ra,
  input  logic [REG_W-1:0] dec_rb,
  input  logic [REG_W-1:0] dec_rc,
  input  logic             dec_rc_reg,
  input  logic             ex_valid,
  input  logic [2:0]       ex_class,
  input  logic [REG_W-1:0] ex_ra,
  input  logic             mem_valid,
  input  logic [2:0]       mem_class,
  input  logic [REG_W-1:0] mem_ra,
  input  logic             wb_valid,
  input  logic [2:0]       wb_class,
  input  logic [REG_W-1:0] wb_ra,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic [1:0]       fwd_c,
  output logic             pause,
  output logic             bubble
);

  logic [PROD_STAGES-1:0]             pv;
  logic [PROD_STAGES-1:0][2:0]        pc;
  logic [PROD_STAGES-1:0][REG_W-1:0]  pr;

  assign pv = {wb_valid, mem_valid, ex_valid};
  assign pc = {wb_class, mem_class, ex_class};
  assign pr = {wb_ra, mem_ra, ex_ra};

  logic       use_a, use_b, use_c;
  logic [2:0] need_a, need_b, need_c;

  hzfwd_use_decode u_dec (
    .valid  (dec_valid),
    .cls    (dec_class),
    .rc_reg (dec_rc_reg),
    .use_a  (use_a),
    .use_b  (use_b),
    .use_c  (use_c),
    .need_a (need_a),
    .need_b (need_b),
    .need_c (need_c)
  );

  // operand order: 0 = rb, 1 = rc, 2 = ra (store data)
  logic [NUM_OPS-1:0]             op_used;
  logic [NUM_OPS-1:0][REG_W-1:0]  op_src;
  logic [NUM_OPS-1:0][2:0]        op_need;
  fwd_sel_t [NUM_OPS-1:0]         op_fwd;
  logic [NUM_OPS-1:0]             op_stall;

  assign op_used = {use_a, use_c, use_b};
  assign op_src  = {dec_ra, dec_rc, dec_rb};
  assign op_need = {need_a, need_c, need_b};

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    hzfwd_operand #(.REG_W(REG_W)) u_op (
      .clk        (clk),
      .rst_n      (rst_n),
      .used       (op_used[k]),
      .src        (op_src[k]),
      .need       (op_need[k]),
      .prod_valid (pv),
      .prod_cls   (pc),
      .prod_ra    (pr),
      .fwd        (op_fwd[k]),
      .stall      (op_stall[k])
    );
  end

  assign fwd_b  = op_fwd[0];
  assign fwd_c  = op_fwd[1];
  assign fwd_a  = op_fwd[2];
  assign pause  = |op_stall;
  assign bubble = |op_stall;

  p_idle_no_pause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !pause && !bubble);

  p_pause_needs_producer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> (ex_valid || mem_valid || wb_valid));

  p_load_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !ex_valid && !mem_valid) |-> 1'b0);

endmodule

// File: tb/tb_hzfwd_unit.sv
module tb_hzfwd_unit;

  typedef struct packed {
    logic       v;
    logic [2:0] c;
    logic [4:0] ra;
  } stg_t;

  typedef struct packed {
    logic       v;
    logic [2:0] c;
    logic [4:0] ra;
    logic [4:0] rb;
    logic [4:0] rc;
    logic       rcr;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  ins_t dq;
  stg_t s3, s4, s5;
  logic [1:0] fwd_a, fwd_b, fwd_c;
  logic pause, bubble;

  int total = 0;
  int bad = 0;

  hzfwd_unit #(.REG_W(5)) dut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dq.v), .dec_class(dq.c), .dec_ra(dq.ra), .dec_rb(dq.rb),
    .dec_rc(dq.rc), .dec_rc_reg(dq.rcr),
    .ex_valid(s3.v), .ex_class(s3.c), .ex_ra(s3.ra),
    .mem_valid(s4.v), .mem_class(s4.c), .mem_ra(s4.ra),
    .wb_valid(s5.v), .wb_class(s5.c), .wb_ra(s5.ra),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_c(fwd_c),
    .pause(pause), .bubble(bubble)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expectation for one operand: youngest producer first
  function automatic void op_model(input bit used, input int src, input int need,
                                   output int f, output bit st);
    stg_t s[3] = '{s3, s4, s5};
    f = 0; st = 0;
    for (int i = 0; i < 3; i++) begin
      if (used && s[i].v && s[i].c <= 3 && int'(s[i].ra) == src) begin
        f  = i + 1;
        st = (need + i + 1) <= ((s[i].c == 1) ? 4 : 3);
        break;
      end
    end
  endfunction

  function automatic void model(output int fa, output int fb, output int fc,
                                output bit p);
    bit ua, ub, uc, br, sa, sb, sc;
    int c;
    c  = int'(dq.c);
    br = (c == 3) || (c == 5);
    ub = dq.v && (c <= 5);
    uc = dq.v && ((c == 0 && dq.rcr) || br);
    ua = dq.v && (c == 4);
    op_model(ub, int'(dq.rb), br ? 2 : 3, fb, sb);
    op_model(uc, int'(dq.rc), br ? 2 : 3, fc, sc);
    op_model(ua, int'(dq.ra), 4, fa, sa);
    p = sa || sb || sc;
  endfunction

  function automatic ins_t mk(input bit v, input int c, input int ra, input int rb,
                              input int rc, input bit rcr);
    ins_t t;
    t.v = v; t.c = 3'(c); t.ra = 5'(ra); t.rb = 5'(rb); t.rc = 5'(rc); t.rcr = rcr;
    return t;
  endfunction

  function automatic stg_t ps(input bit v, input int c, input int ra);
    stg_t t;
    t.v = v; t.c = 3'(c); t.ra = 5'(ra);
    return t;
  endfunction

  task automatic settle();
    @(posedge clk); #1;
  endtask

  // directed comparison against the model plus a stated expectation
  task automatic dir(input string req, input int exp_b, input int exp_p);
    int fa, fb, fc; bit p;
    #2;
    model(fa, fb, fc, p);
    chk(req, int'(fwd_b), exp_b);
    chk(req, int'(pause), exp_p);
    chk(req, {fwd_a, fwd_b, fwd_c}, {2'(fa), 2'(fb), 2'(fc)});
  endtask

  // run producer, optional filler, consumer through a modelled pipeline
  task automatic run_pair(input string req, input ins_t prod, input bit gap,
                          input ins_t cons, input int exp_hold, input int exp_sel,
                          input int sel_op);
    ins_t q[$];
    int holds = 0;
    int last_sel = -1;
    s3 = '0; s4 = '0; s5 = '0; dq = '0;
    q.push_back(prod);
    if (gap) q.push_back(mk(1, 6, 0, 0, 0, 0));
    q.push_back(cons);
    for (int k = 0; k < 4; k++) q.push_back('0);
    dq = q.pop_front();
    for (int cyc = 0; cyc < 8; cyc++) begin
      settle(); #2;
      if (dq == cons && dq.v) begin
        if (pause) holds++;
        else last_sel = (sel_op == 0) ? int'(fwd_b) : int'(fwd_a);
      end
      s5 = s4; s4 = s3;
      if (pause) s3 = '0;
      else begin
        s3 = ps(dq.v, int'(dq.c), int'(dq.ra));
        dq = (q.size() > 0) ? q.pop_front() : '0;
      end
    end
    chk(req, holds, exp_hold);
    chk(req, last_sel, exp_sel);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd13579);
    dq = '0; s3 = '0; s4 = '0; s5 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset/idle state
    settle(); #2;
    chk("R1", {fwd_a, fwd_b, fwd_c, pause, bubble}, 0);
    s3 = ps(1, 0, 4); s4 = ps(1, 1, 4); s5 = ps(1, 0, 4);
    dq = mk(0, 0, 4, 4, 4, 1);
    settle(); #2;
    chk("R1", {fwd_a, fwd_b, fwd_c, pause}, 0);

    // R2 constant second operand ignores rc
    s3 = ps(0, 0, 0); s4 = ps(0, 0, 0); s5 = ps(0, 0, 0);
    dq = mk(1, 0, 9, 1, 7, 0); s3 = ps(1, 1, 7);
    settle(); dir("R2", 0, 0);
    chk("R2", int'(fwd_c), 0);
    // R2 reserved class reads nothing
    dq = mk(1, 6, 7, 7, 7, 1);
    settle(); dir("R2", 0, 0);

    // R3 store producer never a source, r0 compared normally
    s3 = ps(1, 4, 3); s4 = ps(0, 0, 0);
    dq = mk(1, 0, 1, 3, 0, 0);
    settle(); dir("R3", 0, 0);
    s3 = ps(1, 0, 0);
    dq = mk(1, 0, 1, 0, 0, 0);
    settle(); dir("R3", 1, 0);

    // R4 youngest producer wins
    s3 = ps(1, 2, 6); s4 = ps(1, 0, 6); s5 = ps(1, 1, 6);
    dq = mk(1, 1, 2, 6, 0, 0);
    settle(); dir("R4", 1, 0);
    s3 = ps(0, 0, 6);
    settle(); dir("R4", 2, 0);

    // R6 load then alu stalls; load then store data forwards
    s3 = ps(1, 1, 5); s4 = '0; s5 = '0;
    dq = mk(1, 0, 2, 5, 0, 0);
    settle(); dir("R6", 1, 1);
    chk("R9", int'(bubble), 1);
    dq = mk(1, 4, 5, 1, 0, 0);
    settle(); dir("R6", 0, 0);
    chk("R6", int'(fwd_a), 1);

    // R7 load feeding branch at distance 2
    s3 = ps(1, 6, 0); s4 = ps(1, 1, 8);
    dq = mk(1, 5, 0, 8, 2, 0);
    settle(); dir("R7", 2, 1);

    // R8 alu then branch stalls; ladr two back does not
    s3 = ps(1, 0, 8); s4 = '0;
    settle(); dir("R8", 1, 1);
    s3 = ps(1, 6, 0); s4 = ps(1, 2, 8);
    settle(); dir("R8", 2, 0);

    // R5 random patterns against the model
    for (int n = 0; n < 600; n++) begin
      int fa, fb, fc; bit p;
      dq = mk($urandom_range(0, 5) != 0, $urandom_range(0, 7), $urandom_range(0, 3),
              $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1));
      s3 = ps($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3));
      s4 = ps($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3));
      s5 = ps($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3));
      settle(); #2;
      model(fa, fb, fc, p);
      chk("R5", {fwd_a, fwd_b, fwd_c, pause, bubble},
          {2'(fa), 2'(fb), 2'(fc), p, p});
    end

    // R10 hold counts in a running pipeline
    run_pair("R10", mk(1, 1, 4, 1, 0, 0), 0, mk(1, 5, 0, 4, 0, 0), 2, 3, 0);
    run_pair("R10", mk(1, 0, 4, 1, 2, 1), 0, mk(1, 5, 0, 4, 0, 0), 1, 2, 0);
    run_pair("R10", mk(1, 1, 4, 1, 0, 0), 0, mk(1, 0, 7, 4, 0, 0), 1, 2, 0);
    run_pair("R10", mk(1, 1, 4, 1, 0, 0), 0, mk(1, 4, 4, 2, 0, 0), 0, 1, 1);
    run_pair("R10", mk(1, 1, 4, 1, 0, 0), 1, mk(1, 5, 0, 4, 0, 0), 1, 3, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule